// File: doc/BRIEF.md
# ID-Ordered AXI4 Demultiplexer

This block fans one upstream AXI4 port out to `NumPorts` downstream ports. Each write and read address request comes with a port-select input that names its target. Write data beats follow their address requests to the same ports. Write and read responses from every downstream port are merged back onto the single upstream port. The port is picked by the requester, so the block does no address decoding.

Responses can return out of order across ports. To keep same-ID responses in issue order, the block keeps one table for writes and one for reads. Each table has one entry per possible ID. An entry records the port the ID is currently bound to and how many of its transactions are still open. A request whose ID is open on another port waits until that ID has drained. A request whose ID already has `MaxTxn` transactions open also waits. Write data is steered by a small queue of port indices, one per accepted write address. Response merging is round-robin, and a read burst is never interleaved with another one.

Top module: `axi_id_demux`

## Requirements
- R1: An upstream write address with `aw_sel_i = k` raises only `aw_valid_o[k]`. The upstream handshake completes in the same cycle that port k accepts the request.
- R2: An upstream read address with `ar_sel_i = k` raises only `ar_valid_o[k]`. The upstream handshake completes in the same cycle that port k accepts the request.
- R3: Write beats go to ports in the order in which their write addresses were accepted. One burst, ended by `w_last_i`, goes to one port. While no accepted address is waiting for its data, `w_valid_o` and `w_ready_o` stay low.
- R4: A write address whose ID has open writes on a different port is held, with `aw_ready_o` and `aw_valid_o` low. It is held until every write response for that ID has been accepted upstream.
- R5: A read address whose ID has open reads on a different port is held until the read beat with last set has been accepted upstream for each of them. A beat that is not last does not release it.
- R6: Requests with the same ID and the same port pass, up to `MaxTxn` open transactions (default 4). The next one is held until one of them completes.
- R7: Write responses are merged round-robin. When several ports have a response pending, the search starts at the port after the one granted last, and the first pending port wins. After reset the search starts at port 0.
- R8: Read responses use the same round-robin rule. Once a burst's first beat has been accepted, only that port is served until its beat with last set is accepted.
- R9: After reset, with idle inputs, all downstream valids and both upstream response valids are low.
- R10: Requests whose IDs have no open transactions pass to any port without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Upstream write address valid |
| aw_ready_o | output | 1 | Upstream write address ready |
| aw_id_i | input | IdW | Write ID |
| aw_addr_i | input | AddrW | Write address |
| aw_sel_i | input | SelW | Target port for this write |
| w_valid_i | input | 1 | Upstream write data valid |
| w_ready_o | output | 1 | Upstream write data ready |
| w_data_i | input | DataW | Write data |
| w_last_i | input | 1 | Last write beat |
| b_valid_o | output | 1 | Upstream write response valid |
| b_ready_i | input | 1 | Upstream write response ready |
| b_id_o | output | IdW | Write response ID |
| ar_valid_i | input | 1 | Upstream read address valid |
| ar_ready_o | output | 1 | Upstream read address ready |
| ar_id_i | input | IdW | Read ID |
| ar_addr_i | input | AddrW | Read address |
| ar_sel_i | input | SelW | Target port for this read |
| r_valid_o | output | 1 | Upstream read data valid |
| r_ready_i | input | 1 | Upstream read data ready |
| r_id_o | output | IdW | Read data ID |
| r_data_o | output | DataW | Read data |
| r_last_o | output | 1 | Last read beat |
| aw_valid_o | output | NumPorts | Per-port write address valid |
| aw_ready_i | input | NumPorts | Per-port write address ready |
| aw_id_o | output | IdW | Write ID to all ports |
| aw_addr_o | output | AddrW | Write address to all ports |
| w_valid_o | output | NumPorts | Per-port write data valid |
| w_ready_i | input | NumPorts | Per-port write data ready |
| w_data_o | output | DataW | Write data to all ports |
| w_last_o | output | 1 | Last write beat to all ports |
| b_valid_i | input | NumPorts | Per-port write response valid |
| b_ready_o | output | NumPorts | Per-port write response ready |
| b_id_i | input | NumPorts*IdW | Per-port write response IDs, port p at bits p*IdW |
| ar_valid_o | output | NumPorts | Per-port read address valid |
| ar_ready_i | input | NumPorts | Per-port read address ready |
| ar_id_o | output | IdW | Read ID to all ports |
| ar_addr_o | output | AddrW | Read address to all ports |
| r_valid_i | input | NumPorts | Per-port read data valid |
| r_ready_o | output | NumPorts | Per-port read data ready |
| r_id_i | input | NumPorts*IdW | Per-port read IDs, port p at bits p*IdW |
| r_data_i | input | NumPorts*DataW | Per-port read data, port p at bits p*DataW |
| r_last_i | input | NumPorts | Per-port last read beat |

## Verification
The bound checker covers the properties that hold on every cycle:
- Address valids are one-hot or zero.
- An accepted address reached the selected port, and that port was ready.
- Write data reaches at most one port, and only when upstream data is valid.
- A merged write response always has a pending source.
- The read grant does not move between beats of one burst.

Some behaviours depend on history, and only the bench scenarios show them:
- Same-ID stalls that release only on the final response.
- The `MaxTxn` ceiling.
- The order of write data across queued addresses.
- The exact round-robin sequence after a given grant.

// File: rtl/axi_demux_pkg.sv
`timescale 1ns/1ps
package axi_demux_pkg;
  function automatic int unsigned wrap_idx(input int unsigned base, input int unsigned off,
                                           input int unsigned n);
    return (base + off) % n;
  endfunction
endpackage

// File: rtl/demux_id_table.sv
`timescale 1ns/1ps
module demux_id_table #(
  parameter int unsigned IdW    = 3,
  parameter int unsigned SelW   = 2,
  parameter int unsigned MaxTxn = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IdW-1:0]  req_id_i,
  input  logic [SelW-1:0] req_sel_i,
  input  logic            req_fire_i,
  input  logic [IdW-1:0]  done_id_i,
  input  logic            done_fire_i,
  output logic            stall_o
);
  localparam int unsigned NumIds = 2 ** IdW;
  localparam int unsigned CntW   = $clog2(MaxTxn + 1);

  logic [NumIds-1:0][CntW-1:0] cnt_all;
  logic [NumIds-1:0][SelW-1:0] port_all;

  for (genvar g = 0; g < NumIds; g++) begin : g_entry
    logic [CntW-1:0] cnt_q;
    logic [SelW-1:0] port_q;
    logic inc, dec;
    assign inc = req_fire_i && (req_id_i == IdW'(g));
    assign dec = done_fire_i && (done_id_i == IdW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        port_q <= '0;
      end else begin
        if (inc && !dec)      cnt_q <= cnt_q + 1'b1;
        else if (dec && !inc) cnt_q <= cnt_q - 1'b1;
        if (inc) port_q <= req_sel_i;
      end
    end
    assign cnt_all[g]  = cnt_q;
    assign port_all[g] = port_q;
  end

  logic [CntW-1:0] cur_cnt;
  assign cur_cnt = cnt_all[req_id_i];
  // busy on another port, or at the ceiling
  assign stall_o = (cur_cnt == CntW'(MaxTxn)) ||
                   ((cur_cnt != '0) && (port_all[req_id_i] != req_sel_i));
endmodule

// File: rtl/demux_sel_fifo.sv
`timescale 1ns/1ps
module demux_sel_fifo #(
  parameter int unsigned SelW  = 2,
  parameter int unsigned Depth = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [SelW-1:0] data_i,
  input  logic            pop_i,
  output logic [SelW-1:0] data_o,
  output logic            empty_o,
  output logic            full_o
);
  localparam int unsigned PtrW = $clog2(Depth);
  localparam int unsigned CntW = PtrW + 1;

  logic [Depth-1:0][SelW-1:0] mem_q;
  logic [PtrW-1:0] wr_q, rd_q;
  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= wr_q + 1'b1;
      end
      if (pop_i) rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CntW'(push_i) - CntW'(pop_i);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CntW'(Depth));
endmodule

// File: rtl/demux_rr_merge.sv
`timescale 1ns/1ps
module demux_rr_merge import axi_demux_pkg::*; #(
  parameter int unsigned NumPorts  = 4,
  parameter int unsigned PayW      = 8,
  parameter bit          HoldBurst = 1'b0,
  localparam int unsigned SelW     = $clog2(NumPorts)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NumPorts-1:0]           req_i,
  input  logic [NumPorts-1:0][PayW-1:0] pay_i,
  input  logic [NumPorts-1:0]           last_i,
  output logic [NumPorts-1:0]           ready_o,
  output logic                          valid_o,
  input  logic                          ready_i,
  output logic [PayW-1:0]               pay_o,
  output logic                          last_o,
  output logic [SelW-1:0]               gnt_o
);
  logic [SelW-1:0] ptr_q, pick, cand, gnt;
  logic            any, lock_q, fire;
  logic [SelW-1:0] lock_idx_q;

  always_comb begin
    pick = ptr_q;
    any  = 1'b0;
    cand = '0;
    for (int unsigned k = 0; k < NumPorts; k++) begin
      cand = SelW'(wrap_idx(32'(ptr_q), k, NumPorts));
      if (!any && req_i[cand]) begin
        any  = 1'b1;
        pick = cand;
      end
    end
  end

  assign gnt     = lock_q ? lock_idx_q : pick;
  assign valid_o = lock_q ? req_i[lock_idx_q] : any;
  assign pay_o   = pay_i[gnt];
  assign last_o  = last_i[gnt];
  assign gnt_o   = gnt;
  assign fire    = valid_o && ready_i;

  always_comb begin
    ready_o      = '0;
    ready_o[gnt] = ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (fire) ptr_q <= SelW'(wrap_idx(32'(gnt), 1, NumPorts));
  end

  if (HoldBurst) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lock_q     <= 1'b0;
        lock_idx_q <= '0;
      end else if (fire) begin
        lock_q     <= !last_o;
        lock_idx_q <= gnt;
      end
    end
  end else begin : g_free
    assign lock_q     = 1'b0;
    assign lock_idx_q = '0;
  end
endmodule

// File: rtl/axi_id_demux.sv
`timescale 1ns/1ps
module axi_id_demux #(
  parameter int unsigned NumPorts    = 4,
  parameter int unsigned IdW         = 3,
  parameter int unsigned AddrW       = 32,
  parameter int unsigned DataW       = 32,
  parameter int unsigned MaxTxn      = 4,
  parameter int unsigned WrFifoDepth = 4,
  localparam int unsigned SelW       = $clog2(NumPorts)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      aw_valid_i,
  output logic                      aw_ready_o,
  input  logic [IdW-1:0]            aw_id_i,
  input  logic [AddrW-1:0]          aw_addr_i,
  input  logic [SelW-1:0]           aw_sel_i,
  input  logic                      w_valid_i,
  output logic                      w_ready_o,
  input  logic [DataW-1:0]          w_data_i,
  input  logic                      w_last_i,
  output logic                      b_valid_o,
  input  logic                      b_ready_i,
  output logic [IdW-1:0]            b_id_o,
  input  logic                      ar_valid_i,
  output logic                      ar_ready_o,
  input  logic [IdW-1:0]            ar_id_i,
  input  logic [AddrW-1:0]          ar_addr_i,
  input  logic [SelW-1:0]           ar_sel_i,
  output logic                      r_valid_o,
  input  logic                      r_ready_i,
  output logic [IdW-1:0]            r_id_o,
  output logic [DataW-1:0]          r_data_o,
  output logic                      r_last_o,
  output logic [NumPorts-1:0]       aw_valid_o,
  input  logic [NumPorts-1:0]       aw_ready_i,
  output logic [IdW-1:0]            aw_id_o,
  output logic [AddrW-1:0]          aw_addr_o,
  output logic [NumPorts-1:0]       w_valid_o,
  input  logic [NumPorts-1:0]       w_ready_i,
  output logic [DataW-1:0]          w_data_o,
  output logic                      w_last_o,
  input  logic [NumPorts-1:0]       b_valid_i,
  output logic [NumPorts-1:0]       b_ready_o,
  input  logic [NumPorts*IdW-1:0]   b_id_i,
  output logic [NumPorts-1:0]       ar_valid_o,
  input  logic [NumPorts-1:0]       ar_ready_i,
  output logic [IdW-1:0]            ar_id_o,
  output logic [AddrW-1:0]          ar_addr_o,
  input  logic [NumPorts-1:0]       r_valid_i,
  output logic [NumPorts-1:0]       r_ready_o,
  input  logic [NumPorts*IdW-1:0]   r_id_i,
  input  logic [NumPorts*DataW-1:0] r_data_i,
  input  logic [NumPorts-1:0]       r_last_i
);
  localparam int unsigned RPayW = IdW + DataW;

  logic aw_stall, ar_stall, aw_go, ar_go, w_go;
  logic wq_empty, wq_full, w_pop;
  logic [SelW-1:0] wq_head, r_gnt, b_gnt_unused;
  logic b_last_unused;
  logic [NumPorts-1:0][RPayW-1:0] r_pay;

  assign aw_go      = aw_valid_i && !aw_stall && !wq_full;
  assign ar_go      = ar_valid_i && !ar_stall;
  assign aw_ready_o = aw_go && aw_ready_i[aw_sel_i];
  assign ar_ready_o = ar_go && ar_ready_i[ar_sel_i];
  assign aw_id_o    = aw_id_i;
  assign aw_addr_o  = aw_addr_i;
  assign ar_id_o    = ar_id_i;
  assign ar_addr_o  = ar_addr_i;

  assign w_go      = w_valid_i && !wq_empty;
  assign w_ready_o = w_go && w_ready_i[wq_head];
  assign w_pop     = w_ready_o && w_last_i;
  assign w_data_o  = w_data_i;
  assign w_last_o  = w_last_i;

  always_comb begin
    aw_valid_o           = '0;
    aw_valid_o[aw_sel_i] = aw_go;
    ar_valid_o           = '0;
    ar_valid_o[ar_sel_i] = ar_go;
    w_valid_o            = '0;
    w_valid_o[wq_head]   = w_go;
  end

  demux_id_table #(.IdW(IdW), .SelW(SelW), .MaxTxn(MaxTxn)) i_wr_table (
    .clk_i, .rst_ni,
    .req_id_i(aw_id_i), .req_sel_i(aw_sel_i), .req_fire_i(aw_ready_o),
    .done_id_i(b_id_o), .done_fire_i(b_valid_o && b_ready_i),
    .stall_o(aw_stall)
  );

  demux_id_table #(.IdW(IdW), .SelW(SelW), .MaxTxn(MaxTxn)) i_rd_table (
    .clk_i, .rst_ni,
    .req_id_i(ar_id_i), .req_sel_i(ar_sel_i), .req_fire_i(ar_ready_o),
    .done_id_i(r_id_o), .done_fire_i(r_valid_o && r_ready_i && r_last_o),
    .stall_o(ar_stall)
  );

  demux_sel_fifo #(.SelW(SelW), .Depth(WrFifoDepth)) i_w_route (
    .clk_i, .rst_ni,
    .push_i(aw_ready_o), .data_i(aw_sel_i), .pop_i(w_pop),
    .data_o(wq_head), .empty_o(wq_empty), .full_o(wq_full)
  );

  demux_rr_merge #(.NumPorts(NumPorts), .PayW(IdW), .HoldBurst(1'b0)) i_b_merge (
    .clk_i, .rst_ni,
    .req_i(b_valid_i), .pay_i(b_id_i), .last_i({NumPorts{1'b1}}), .ready_o(b_ready_o),
    .valid_o(b_valid_o), .ready_i(b_ready_i), .pay_o(b_id_o), .last_o(b_last_unused),
    .gnt_o(b_gnt_unused)
  );

  for (genvar p = 0; p < NumPorts; p++) begin : g_rpay
    assign r_pay[p] = {r_id_i[p*IdW +: IdW], r_data_i[p*DataW +: DataW]};
  end

  demux_rr_merge #(.NumPorts(NumPorts), .PayW(RPayW), .HoldBurst(1'b1)) i_r_merge (
    .clk_i, .rst_ni,
    .req_i(r_valid_i), .pay_i(r_pay), .last_i(r_last_i), .ready_o(r_ready_o),
    .valid_o(r_valid_o), .ready_i(r_ready_i), .pay_o({r_id_o, r_data_o}), .last_o(r_last_o),
    .gnt_o(r_gnt)
  );
endmodule

// File: rtl/axi_id_demux_chk.sv
`timescale 1ns/1ps
module axi_id_demux_chk #(
  parameter int unsigned NumPorts = 4,
  localparam int unsigned SelW    = $clog2(NumPorts)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                aw_valid_i,
  input logic                aw_ready_o,
  input logic [SelW-1:0]     aw_sel_i,
  input logic [NumPorts-1:0] aw_valid_o,
  input logic [NumPorts-1:0] aw_ready_i,
  input logic                ar_valid_i,
  input logic                ar_ready_o,
  input logic [SelW-1:0]     ar_sel_i,
  input logic [NumPorts-1:0] ar_valid_o,
  input logic [NumPorts-1:0] ar_ready_i,
  input logic                w_valid_i,
  input logic [NumPorts-1:0] w_valid_o,
  input logic                b_valid_o,
  input logic [NumPorts-1:0] b_valid_i,
  input logic                r_valid_o,
  input logic                r_ready_i,
  input logic                r_last_o,
  input logic [SelW-1:0]     r_gnt
);
  // R1
  aw_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(aw_valid_o));
  // R1
  aw_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_valid_i && aw_ready_o) |-> (aw_valid_o[aw_sel_i] && aw_ready_i[aw_sel_i]));
  // R2
  ar_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(ar_valid_o));
  // R2
  ar_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ar_valid_i && ar_ready_o) |-> (ar_valid_o[ar_sel_i] && ar_ready_i[ar_sel_i]));
  // R3
  w_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(w_valid_o));
  // R3
  w_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|w_valid_o) |-> w_valid_i);
  // R7
  b_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o |-> (|b_valid_i));
  // R8
  r_burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && r_ready_i && !r_last_o) |=> (r_gnt == $past(r_gnt)));
endmodule

bind axi_id_demux axi_id_demux_chk #(.NumPorts(NumPorts)) i_axi_id_demux_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .aw_valid_i(aw_valid_i), .aw_ready_o(aw_ready_o), .aw_sel_i(aw_sel_i),
  .aw_valid_o(aw_valid_o), .aw_ready_i(aw_ready_i),
  .ar_valid_i(ar_valid_i), .ar_ready_o(ar_ready_o), .ar_sel_i(ar_sel_i),
  .ar_valid_o(ar_valid_o), .ar_ready_i(ar_ready_i),
  .w_valid_i(w_valid_i), .w_valid_o(w_valid_o),
  .b_valid_o(b_valid_o), .b_valid_i(b_valid_i),
  .r_valid_o(r_valid_o), .r_ready_i(r_ready_i), .r_last_o(r_last_o), .r_gnt(r_gnt)
);

// File: tb/test_axi_id_demux.sv
`timescale 1ns/1ps
module test_axi_id_demux;
  localparam int N = 4, IW = 3, AW = 32, DW = 32, SW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic aw_valid_i = 0, w_valid_i = 0, w_last_i = 0, b_ready_i = 1;
  logic ar_valid_i = 0, r_ready_i = 1;
  logic [IW-1:0] aw_id_i = '0, ar_id_i = '0;
  logic [AW-1:0] aw_addr_i = '0, ar_addr_i = '0;
  logic [SW-1:0] aw_sel_i = '0, ar_sel_i = '0;
  logic [DW-1:0] w_data_i = '0;
  logic [N-1:0] aw_ready_i = '1, w_ready_i = '1, ar_ready_i = '1;
  logic [N-1:0] b_valid_i = '0, r_valid_i = '0, r_last_i = '0;
  logic [N*IW-1:0] b_id_i = '0, r_id_i = '0;
  logic [N*DW-1:0] r_data_i = '0;

  logic aw_ready_o, w_ready_o, b_valid_o, ar_ready_o, r_valid_o, r_last_o, w_last_o;
  logic [IW-1:0] b_id_o, r_id_o, aw_id_o, ar_id_o;
  logic [DW-1:0] r_data_o, w_data_o;
  logic [AW-1:0] aw_addr_o, ar_addr_o;
  logic [N-1:0] aw_valid_o, w_valid_o, b_ready_o, ar_valid_o, r_ready_o;

  axi_id_demux #(.NumPorts(N), .IdW(IW), .AddrW(AW), .DataW(DW), .MaxTxn(4), .WrFifoDepth(4))
  i_axi_id_demux (
    .clk_i(clk), .rst_ni,
    .aw_valid_i, .aw_ready_o, .aw_id_i, .aw_addr_i, .aw_sel_i,
    .w_valid_i, .w_ready_o, .w_data_i, .w_last_i,
    .b_valid_o, .b_ready_i, .b_id_o,
    .ar_valid_i, .ar_ready_o, .ar_id_i, .ar_addr_i, .ar_sel_i,
    .r_valid_o, .r_ready_i, .r_id_o, .r_data_o, .r_last_o,
    .aw_valid_o, .aw_ready_i, .aw_id_o, .aw_addr_o,
    .w_valid_o, .w_ready_i, .w_data_o, .w_last_o,
    .b_valid_i, .b_ready_o, .b_id_i,
    .ar_valid_o, .ar_ready_i, .ar_id_o, .ar_addr_o,
    .r_valid_i, .r_ready_o, .r_id_i, .r_data_i, .r_last_i
  );

  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_aw(input int id, input int sel, input string req);
    @(negedge clk);
    aw_valid_i = 1; aw_id_i = IW'(id); aw_sel_i = SW'(sel); aw_addr_i = AW'(32'h100 + id);
    #1;
    check(aw_valid_o == N'(1 << sel), req, int'(aw_valid_o), 1 << sel);
    check(aw_ready_o == 1'b1, req, int'(aw_ready_o), 1);
    @(posedge clk); #1 aw_valid_i = 0;
  endtask

  task automatic send_ar(input int id, input int sel, input string req);
    @(negedge clk);
    ar_valid_i = 1; ar_id_i = IW'(id); ar_sel_i = SW'(sel); ar_addr_i = AW'(32'h200 + id);
    #1;
    check(ar_valid_o == N'(1 << sel), req, int'(ar_valid_o), 1 << sel);
    check(ar_ready_o == 1'b1, req, int'(ar_ready_o), 1);
    @(posedge clk); #1 ar_valid_i = 0;
  endtask

  task automatic expect_aw_stall(input int id, input int sel, input string req);
    @(negedge clk);
    aw_valid_i = 1; aw_id_i = IW'(id); aw_sel_i = SW'(sel);
    #1;
    check(aw_valid_o == '0 && aw_ready_o == 1'b0, req, int'(aw_valid_o), 0);
    @(posedge clk); #1 aw_valid_i = 0;
  endtask

  task automatic expect_ar_stall(input int id, input int sel, input string req);
    @(negedge clk);
    ar_valid_i = 1; ar_id_i = IW'(id); ar_sel_i = SW'(sel);
    #1;
    check(ar_valid_o == '0 && ar_ready_o == 1'b0, req, int'(ar_valid_o), 0);
    @(posedge clk); #1 ar_valid_i = 0;
  endtask

  task automatic send_w(input int beats, input int port, input string req);
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      w_valid_i = 1; w_last_i = (b == beats - 1); w_data_i = DW'(port * 16 + b);
      #1;
      check(w_valid_o == N'(1 << port), req, int'(w_valid_o), 1 << port);
      check(w_ready_o && w_data_o == DW'(port * 16 + b), req, int'(w_data_o), port * 16 + b);
      @(posedge clk); #1 w_valid_i = 0; w_last_i = 0;
    end
  endtask

  task automatic send_b(input int port, input int id, input string req);
    @(negedge clk);
    b_valid_i[port] = 1; b_id_i[port*IW +: IW] = IW'(id);
    #1;
    check(b_valid_o && b_ready_o[port] && b_id_o == IW'(id), req, int'(b_id_o), id);
    @(posedge clk); #1 b_valid_i = '0;
  endtask

  task automatic r_beat(input int port, input int id, input bit last, input string req);
    @(negedge clk);
    r_valid_i[port] = 1; r_last_i[port] = last; r_id_i[port*IW +: IW] = IW'(id);
    r_data_i[port*DW +: DW] = DW'(id * 7 + port);
    #1;
    check(r_valid_o && r_ready_o[port] && r_id_o == IW'(id) && r_last_o == last,
          req, int'(r_id_o), id);
    check(r_data_o == DW'(id * 7 + port), req, int'(r_data_o), id * 7 + port);
    @(posedge clk); #1 r_valid_i = '0; r_last_i = '0;
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R9
    check(aw_valid_o == '0 && ar_valid_o == '0 && w_valid_o == '0, "R9",
          int'({aw_valid_o, ar_valid_o, w_valid_o}), 0);
    check(!b_valid_o && !r_valid_o, "R9", int'({b_valid_o, r_valid_o}), 0);
    rst_ni = 1;
  endtask

  task automatic t_write_routes();
    int exp_seq[3] = '{3, 0, 1};
    logic [N-1:0] pend;
    int gp;
    for (int p = 0; p < N; p++) send_aw(p, p, "R1");
    for (int p = 0; p < N; p++) send_w(1, p, "R3");
    send_b(2, 2, "R7");
    // pointer now at 3: pending {0,1,3} must come out 3, 0, 1
    pend = 4'b1011;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      b_valid_i = pend;
      for (int p = 0; p < N; p++) b_id_i[p*IW +: IW] = IW'(p);
      #1;
      gp = -1;
      for (int p = 0; p < N; p++) if (b_ready_o[p]) gp = p;
      check(b_valid_o && gp == exp_seq[n] && b_id_o == IW'(exp_seq[n]), "R7", gp, exp_seq[n]);
      @(posedge clk);
      if (gp >= 0) pend[gp] = 1'b0;
    end
    #1 b_valid_i = '0;
  endtask

  task automatic t_w_order();
    @(negedge clk);
    w_valid_i = 1; w_last_i = 1;
    #1;
    check(w_valid_o == '0 && !w_ready_o, "R3", int'(w_valid_o), 0);
    @(posedge clk); #1 w_valid_i = 0; w_last_i = 0;
    send_aw(5, 2, "R1");
    send_aw(6, 0, "R1");
    send_w(2, 2, "R3");
    send_w(1, 0, "R3");
    send_b(2, 5, "R7");
    send_b(0, 6, "R7");
  endtask

  task automatic t_wr_stall();
    send_aw(1, 1, "R1");
    send_w(1, 1, "R3");
    expect_aw_stall(1, 2, "R4");
    send_aw(2, 2, "R10");
    send_w(1, 2, "R3");
    expect_aw_stall(1, 2, "R4");
    send_b(1, 1, "R4");
    send_aw(1, 2, "R4");
    send_w(1, 2, "R3");
    send_b(2, 2, "R7");
    send_b(2, 1, "R7");
  endtask

  task automatic t_rd_stall();
    send_ar(4, 0, "R2");
    expect_ar_stall(4, 3, "R5");
    r_beat(0, 4, 1'b0, "R5");
    expect_ar_stall(4, 3, "R5");
    r_beat(0, 4, 1'b1, "R5");
    send_ar(4, 3, "R5");
    r_beat(3, 4, 1'b1, "R5");
  endtask

  task automatic t_max();
    for (int k = 0; k < 4; k++) send_ar(3, 1, "R6");
    expect_ar_stall(3, 1, "R6");
    r_beat(1, 3, 1'b1, "R6");
    send_ar(3, 1, "R6");
    for (int k = 0; k < 4; k++) r_beat(1, 3, 1'b1, "R6");
  endtask

  task automatic t_r_lock();
    int rem[N];
    int gp;
    send_ar(6, 1, "R2");
    send_ar(7, 2, "R2");
    rem = '{0, 3, 3, 0};
    // last grant was port 1, so port 2 leads; no interleave
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      for (int p = 0; p < N; p++) begin
        r_valid_i[p] = (rem[p] > 0);
        r_last_i[p]  = (rem[p] == 1);
        r_id_i[p*IW +: IW] = (p == 1) ? IW'(6) : IW'(7);
        r_data_i[p*DW +: DW] = DW'(p * 256 + rem[p]);
      end
      #1;
      gp = -1;
      for (int p = 0; p < N; p++) if (r_ready_o[p]) gp = p;
      check(r_valid_o && gp == ((n < 3) ? 2 : 1), "R8", gp, (n < 3) ? 2 : 1);
      check(r_id_o == ((n < 3) ? IW'(7) : IW'(6)), "R8", int'(r_id_o), (n < 3) ? 7 : 6);
      check(r_last_o == (n == 2 || n == 5), "R8", int'(r_last_o), int'(n == 2 || n == 5));
      check(r_data_o == DW'(((n < 3) ? 512 : 256) + 3 - (n % 3)), "R8", int'(r_data_o),
            ((n < 3) ? 512 : 256) + 3 - (n % 3));
      @(posedge clk);
      if (gp >= 0) rem[gp]--;
    end
    #1 r_valid_i = '0; r_last_i = '0;
  endtask

  initial begin
    t_reset();
    t_write_routes();
    t_w_order();
    t_wr_stall();
    t_rd_stall();
    t_max();
    t_r_lock();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule